// File: doc/BRIEF.md
# Two-Wire Control Register Target with Status Readback

This block is a target-only two-wire serial port (I2C, fast mode up to 400 kHz) that lets a baseband controller load a bank of 8-bit control registers and fetch a status byte. Both bus lines are taken in through synchronizers on a much faster system clock. Bus events are found by comparing each synchronized sample with the one from the cycle before: a START or STOP, and a rising or falling edge of SCL.

Two strap pins pick the device address out of three fixed values. A write transfer carries a register pointer and then data bytes. Each data byte lands in the register the pointer names, and the pointer then advances by one. A read transfer has no pointer. It streams a status byte first and then a reserved byte. The status byte is a snapshot of two external detector flags: overcurrent and load present. SDA is driven only as an open-drain pull-down enable.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset every control register reads 0x00 and `sdaOe` is low.
- R2: Address bytes are shifted most significant bit first, and bit 0 is the direction (1 = read). `addrSel` picks the 7-bit address as follows: 00 gives 0x63 (bytes 0xC6 write, 0xC7 read); 01 gives 0x62 (0xC4/0xC5); 10 and 11 both give 0x61 (0xC2/0xC3).
- R3: A matching address byte is acknowledged by holding SDA low through the ninth SCL pulse. A non-matching one gets no acknowledge, and SDA is then never driven until the next START.
- R4: In a write, the first byte after the address loads the register pointer. Each later byte is stored into the register the pointer selects, and the pointer then increments by one. Every byte of a matched write is acknowledged. A write continues until STOP.
- R5: Data bytes that arrive while the pointer is at or above `NUM_REGS` are acknowledged but change no register. The pointer does not wrap into the bank.
- R6: A read returns the status byte as its first byte, MSB first. Status bit 0 is `overCurrent`, bit 1 is `loadPresent`, and bits 7:2 are zero. The second and every later byte is `RESERVED_VAL` (default 0x00).
- R7: The status byte is captured at the end of the read address byte. Detector changes after that point do not alter the byte being returned.
- R8: After the controller NACKs a read byte, SDA is released and stays released until the next STOP or START.
- R9: A START seen anywhere restarts address reception and discards a partly received byte. A STOP returns the block to idle without touching any register.
- R10: `sdaOe` changes only while SCL is low, never during a stable high phase of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| addrSel | input | 2 | Strap pins that pick the device address |
| overCurrent | input | 1 | Overcurrent detector flag (status bit 0) |
| loadPresent | input | 1 | Load-present detector flag (status bit 1) |
| regBank | output | NUM_REGS*8 | Control registers, register r at bits [8r+7:8r] |

## Verification
A wrong pointer or a missed write shows on `regBank` before the ninth SCL pulse of the affected byte rises. The bench model compares the whole bank on every clock while SCL is high. A wrong control state shows within one bit time as an acknowledge that is missing or unexpected, or as SDA held low when it should be released. A stale or early status capture shows as a wrong first read byte once the detectors are moved right after the address acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_RNXT,
    ST_HOLD
  } tgtState_e;

  // strobes from control to datapath, each one clock wide
  typedef struct packed {
    logic shiftIn;        // take sdaLvl into the receive shifter
    logic capStatus;      // freeze detector flags for a read
    logic loadPtr;        // receive shifter -> pointer
    logic writeReg;       // receive shifter -> register[pointer], pointer+1
    logic loadTx;         // load the transmit shifter
    logic txSelReserved;  // with loadTx: reserved byte instead of status
    logic shiftTx;        // present next transmit bit
  } dpStrobe_t;

  function automatic logic [6:0] addrFor(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'h63;
      2'b01:   return 7'h62;
      default: return 7'h61;
    endcase
  endfunction

endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler #(
  parameter int               SYNC_STAGES = 2,
  parameter int               LANES       = 4,
  parameter logic [LANES-1:0] RST_VAL     = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] rawIn,
  output logic [LANES-1:0] lvl
);

  // one synchronizer chain per asynchronous input; SYNC_STAGES must be >= 2
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {SYNC_STAGES{RST_VAL[g]}};
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign lvl[g] = pipe[SYNC_STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic [1:0] addrSel,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  strobe,
  output logic       sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  tgtState_e  state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic       ackDrv, ackDrvN;
  logic       txActive, txActiveN;
  logic       isRead, isReadN;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet, byteDone;
  logic [6:0] myAddr;

  assign myAddr   = addrFor(addrSel);
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign byteDone = (bitCnt == LAST_BIT);

  always_comb begin
    stateN    = state;
    bitCntN   = bitCnt;
    ackDrvN   = ackDrv;
    txActiveN = txActive;
    isReadN   = isRead;
    strobe    = '0;
    if (startDet) begin
      stateN    = ST_ADDR;
      bitCntN   = '0;
      ackDrvN   = 1'b0;
      txActiveN = 1'b0;
    end else if (stopDet) begin
      stateN    = ST_IDLE;
      bitCntN   = '0;
      ackDrvN   = 1'b0;
      txActiveN = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            bitCntN        = bitCnt + 4'd1;
          end else if (sclFall && byteDone) begin
            bitCntN = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == myAddr) begin
                ackDrvN          = 1'b1;
                isReadN          = rxByte[0];
                strobe.capStatus = rxByte[0];
                stateN           = ST_AACK;
              end else begin
                stateN = ST_HOLD;
              end
            end else if (state == ST_PTR) begin
              strobe.loadPtr = 1'b1;
              ackDrvN        = 1'b1;
              stateN         = ST_PACK;
            end else begin
              strobe.writeReg = 1'b1;
              ackDrvN         = 1'b1;
              stateN          = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            ackDrvN = 1'b0;
            if (isRead) begin
              strobe.loadTx = 1'b1;
              txActiveN     = 1'b1;
              stateN        = ST_RDATA;
            end else begin
              stateN = ST_PTR;
            end
          end
        end
        ST_PACK, ST_WACK: begin
          if (sclFall) begin
            ackDrvN = 1'b0;
            stateN  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (byteDone) begin
              txActiveN = 1'b0;
              bitCntN   = '0;
              stateN    = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) stateN = sdaLvl ? ST_HOLD : ST_RNXT;
        end
        ST_RNXT: begin
          if (sclFall) begin
            strobe.loadTx        = 1'b1;
            strobe.txSelReserved = 1'b1;
            txActiveN            = 1'b1;
            stateN               = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrv   <= 1'b0;
      txActive <= 1'b0;
      isRead   <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      ackDrv   <= ackDrvN;
      txActive <= txActiveN;
      isRead   <= isReadN;
      sclPrev  <= sclLvl;
      sdaPrev  <= sdaLvl;
    end
  end

  assign sdaOe = ackDrv | (txActive & ~txMsb);

  // R3: idle or ignoring the bus means the line is left alone
  a_r3_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_HOLD) |-> !sdaOe);

  // R8: the controller's acknowledge slot after a read byte is never driven
  a_r8_release_in_ack_slot: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK) |-> !sdaOe);

  // R10: the drive only moves in the cycle after a falling SCL edge or a bus condition
  a_r10_drive_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sclFall || startDet || stopDet) |-> $stable(sdaOe));

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int          NUM_REGS     = 8,
  parameter logic [7:0]  RESERVED_VAL = 8'h00
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic                       sdaLvl,
  input  logic [BYTE_W-1:0]          statusIn,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txMsb,
  output logic [NUM_REGS*BYTE_W-1:0] regBank
);

  localparam int               PTR_W     = 8;
  localparam logic [PTR_W:0]   REG_LIMIT = (PTR_W+1)'(NUM_REGS);

  logic [BYTE_W-1:0] rxShift, txShift, statusSnap;
  logic [PTR_W-1:0]  ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      statusSnap <= '0;
      ptr        <= '0;
    end else begin
      if (strobe.shiftIn)   rxShift    <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (strobe.capStatus) statusSnap <= statusIn;
      if (strobe.loadTx)
        txShift <= strobe.txSelReserved ? RESERVED_VAL : statusSnap;
      else if (strobe.shiftTx)
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strobe.loadPtr)       ptr <= rxShift;
      else if (strobe.writeReg) ptr <= ptr + 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [BYTE_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      val <= '0;
      else if (strobe.writeReg && ptr == PTR_W'(r))   val <= rxShift;
    end
    assign regBank[r*BYTE_W +: BYTE_W] = val;
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[BYTE_W-1];

  // R4: every stored byte advances the pointer by exactly one
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeReg |=> (ptr == $past(ptr) + 1'b1));

  // R5: a byte aimed past the bank leaves every register untouched
  a_r5_oob_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeReg && ({1'b0, ptr} >= REG_LIMIT)) |=> $stable(regBank));

  // R7: the frozen status only follows the detectors at a capture strobe
  a_r7_snap_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && !strobe.txSelReserved) |=> (txShift == $past(statusSnap)));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS     = 8,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] RESERVED_VAL = 8'h00
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  input  logic [1:0]                 addrSel,
  input  logic                       overCurrent,
  input  logic                       loadPresent,
  output logic [NUM_REGS*BYTE_W-1:0] regBank
);

  localparam int LANES = 4;

  logic [LANES-1:0]  lvl;
  logic [BYTE_W-1:0] rxByte, statusIn;
  logic              txMsb;
  dpStrobe_t         strobe;

  i2c_tgt_sampler #(
    .SYNC_STAGES (SYNC_STAGES),
    .LANES       (LANES),
    .RST_VAL     (4'b0011)
  ) sampler_i (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn ({loadPresent, overCurrent, sdaIn, sclIn}),
    .lvl   (lvl)
  );

  assign statusIn = {6'b0, lvl[3], lvl[2]};

  i2c_tgt_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclLvl  (lvl[0]),
    .sdaLvl  (lvl[1]),
    .addrSel (addrSel),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .strobe  (strobe),
    .sdaOe   (sdaOe)
  );

  i2c_tgt_dp #(
    .NUM_REGS     (NUM_REGS),
    .RESERVED_VAL (RESERVED_VAL)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdaLvl   (lvl[1]),
    .statusIn (statusIn),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .regBank  (regBank)
  );

endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

  localparam int NUM_REGS = 8;
  localparam int Q        = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic mScl = 1'b1, mSdaLow = 1'b0;
  logic [1:0] addrSel = 2'b00;
  logic overCurrent = 1'b0, loadPresent = 1'b0;
  logic sdaOe;
  logic [NUM_REGS*8-1:0] regBank;
  wire  sdaBus = ~(mSdaLow | sdaOe);

  i2c_reg_target #(.NUM_REGS(NUM_REGS)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .addrSel(addrSel), .overCurrent(overCurrent), .loadPresent(loadPresent),
    .regBank(regBank)
  );

  int vectors = 0, miscompares = 0, cycles = 0, sclHigh = 0;
  logic [7:0] expReg [NUM_REGS];
  logic [7:0] wrQ [$];
  bit monOn = 0, expectQuiet = 0;
  logic prevOe = 1'b0;

  function automatic logic [NUM_REGS*8-1:0] expFlat();
    logic [NUM_REGS*8-1:0] f;
    for (int i = 0; i < NUM_REGS; i++) f[i*8 +: 8] = expReg[i];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog got %0d cycles exp completion", cycles);
      summary();
    end
    sclHigh = mScl ? sclHigh + 1 : 0;
    if (monOn) begin
      if (mScl) chk("R4/R5 register bank", regBank, expFlat());
      if (sclHigh >= 4) chk("R10 drive steady while SCL high", sdaOe, prevOe);
      if (expectQuiet) chk("R3 no drive after address mismatch", sdaOe, 1'b0);
    end
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    mSdaLow = ~b; tick(Q); mScl = 1'b1; tick(2*Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic v);
    mSdaLow = 1'b0; tick(Q); mScl = 1'b1; tick(Q); v = sdaBus; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(Q); mScl = 1'b1; tick(Q); mSdaLow = 1'b1; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(Q); mScl = 1'b1; tick(Q); mSdaLow = 1'b0; tick(Q);
  endtask

  // model update happens after the eighth bit, before the acknowledge pulse
  task automatic sendByte(input logic [7:0] b, input int regIdx, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    if (regIdx >= 0 && regIdx < NUM_REGS) expReg[regIdx] = b;
    recvBit(v);
    acked = ~v;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin recvBit(v); b[i] = v; end
    sendBit(~giveAck);
  endtask

  task automatic doWrite(input logic [7:0] addrB, input logic [7:0] ptr, input logic match);
    logic a;
    int p;
    if (!match) expectQuiet = 1;
    busStart();
    sendByte(addrB, -1, a);
    chk(match ? "R2/R3 write address acknowledged" : "R2/R3 foreign address not acknowledged", a, match);
    sendByte(ptr, -1, a);
    chk("R4 pointer byte ack", a, match);
    p = ptr;
    foreach (wrQ[k]) begin
      sendByte(wrQ[k], match ? p : -1, a);
      chk("R4/R5 data byte ack", a, match);
      p = (p + 1) % 256;
    end
    busStop();
    expectQuiet = 0;
  endtask

  task automatic doRead(input logic [7:0] addrB, input int n, input logic match,
                        input logic chg, input logic chgOc, input logic chgLp,
                        input logic [7:0] exp0);
    logic a, v;
    logic [7:0] b;
    if (!match) expectQuiet = 1;
    busStart();
    sendByte(addrB, -1, a);
    chk(match ? "R2/R3 read address acknowledged" : "R2/R3 foreign read address not acknowledged", a, match);
    if (match) begin
      if (chg) begin overCurrent = chgOc; loadPresent = chgLp; end
      for (int k = 0; k < n; k++) begin
        recvByte(k < n - 1, b);
        if (k == 0) chk("R6/R7 status byte", b, exp0);
        else        chk("R6 reserved byte", b, 8'h00);
      end
      for (int c = 0; c < 2*Q; c++) begin
        tick(1);
        chk("R8 released after NACK", sdaOe, 1'b0);
      end
      recvBit(v);
      chk("R8 line stays high after NACK", v, 1'b1);
    end
    busStop();
    expectQuiet = 0;
  endtask

  initial begin
    logic a;
    for (int i = 0; i < NUM_REGS; i++) expReg[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk("R1 sdaOe after reset", sdaOe, 1'b0);
    chk("R1 registers after reset", regBank, '0);
    monOn = 1;

    // R2/R4: strap 00 answers 0xC6 only
    addrSel = 2'b00;
    wrQ = {8'h0E, 8'hD8, 8'h26};
    doWrite(8'hC6, 8'h01, 1'b1);
    wrQ = {8'h11, 8'h22};
    doWrite(8'hC4, 8'h00, 1'b0);
    doWrite(8'hC2, 8'h00, 1'b0);

    // R2: strap 01
    addrSel = 2'b01;
    wrQ = {8'hA5};
    doWrite(8'hC4, 8'h00, 1'b1);
    doWrite(8'hC6, 8'h05, 1'b0);

    // R2: strap 10
    addrSel = 2'b10;
    wrQ = {8'h3C, 8'hC3};
    doWrite(8'hC2, 8'h04, 1'b1);

    // R2/R5: strap 11, write runs past the bank end
    addrSel = 2'b11;
    wrQ = {8'h77, 8'h88, 8'h99};
    doWrite(8'hC2, 8'h06, 1'b1);
    wrQ = {8'h01};
    doWrite(8'hC4, 8'h00, 1'b0);

    // R6/R7: detectors move right after the address acknowledge
    overCurrent = 1'b1; loadPresent = 1'b0;
    tick(4*Q);
    doRead(8'hC3, 2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01);
    doRead(8'hC3, 3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02);
    addrSel = 2'b00;
    doRead(8'hC3, 1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    doRead(8'hC7, 1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02);
    overCurrent = 1'b1; loadPresent = 1'b1;
    tick(4*Q);
    doRead(8'hC7, 1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03);

    // R9: repeated START in the middle of a data byte
    busStart();
    sendByte(8'hC6, -1, a);
    chk("R9 address before restart", a, 1'b1);
    sendByte(8'h02, -1, a);
    chk("R9 pointer before restart", a, 1'b1);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    wrQ = {8'h5A};
    doWrite(8'hC6, 8'h00, 1'b1);

    // R9: STOP in the middle of a data byte, then a clean read
    busStart();
    sendByte(8'hC6, -1, a);
    chk("R9 address before stop", a, 1'b1);
    sendByte(8'h03, -1, a);
    chk("R9 pointer before stop", a, 1'b1);
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    busStop();
    tick(4*Q);
    chk("R9 partial byte discarded", regBank, expFlat());
    doRead(8'hC7, 2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03);

    tick(10);
    summary();
  end

endmodule